// File: doc/BRIEF.md
# SPI Slave Byte Shift Engine

This block is the receive and transmit engine of a serial peripheral interface slave. An external master drives a serial clock, a data-in line and an active-low select. The block shifts out a byte from a local holding register on the data-out line, MSB first. At the same time it shifts in a byte from the master. Each completed byte appears on a parallel bus together with a strobe that lasts one cycle. The data-out pin is meant for a tri-state pad, so the block provides an output enable next to the data bit.

Clock polarity and clock phase are set by configuration inputs. All three pins are asynchronous to the system clock. Each passes through a two-flop synchronizer, and serial clock edges are found in the system clock domain. For that reason the serial clock must run at no more than a quarter of the system clock.

The clock phase changes how bytes are framed. With phase 0, a byte starts when select falls, and select must go high again before the next byte. With phase 1, select may stay low while several bytes follow one another. In both phases, raising select drops any partly received byte. If the mode-fault enable is set, that abort also raises a sticky fault flag.

Top module: `spi_slave_engine`

## Requirements
- R1: A byte takes exactly 8 serial clock cycles and is shifted MSB first in both directions. After the eighth sampling edge, `rx_data` holds the received byte and `rx_valid` is high for exactly one system clock cycle.
- R2: With `cfg_cpha`=0, the MSB of the transmit byte is on `miso_out` once select is low and before the first serial clock edge. The leading edge samples and the trailing edge changes data. The leading edge is the rising edge when `cfg_cpol`=0 and the falling edge when `cfg_cpol`=1.
- R3: With `cfg_cpha`=0, serial clock edges that follow a finished byte are ignored until select goes high and then low again.
- R4: With `cfg_cpha`=1, the leading edge changes data and the trailing edge samples it. Select may stay low, and the next byte starts on the first leading edge after a byte completes.
- R5: `miso_out` is not driven while `pin_sel_n` is high: `miso_oe`=0.
- R6: Serial clock edges are ignored while select is high. If select rises partway through a byte, the partial byte is discarded and the bit count restarts from zero.
- R7: `fault_flag` is set when select rises partway through a byte, but only if `fault_en`=1. It stays set until `fault_clr` is pulsed.
- R8: The byte written by `tx_load` is kept. If no new byte is loaded, each later byte transmits the same value again.
- R9: If `rx_valid` fires while an earlier byte has not been taken with `rx_take`, `rx_overrun` is set. A `rx_take` pulse clears `rx_overrun` and marks the received byte as consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Clock phase: 0 = sample on leading edge, 1 = sample on trailing edge |
| fault_en | input | 1 | Allows an aborted byte to set `fault_flag` |
| fault_clr | input | 1 | Clears `fault_flag` |
| pin_sck | input | 1 | Serial clock from the master (asynchronous) |
| pin_mosi | input | 1 | Serial data from the master (asynchronous) |
| pin_sel_n | input | 1 | Slave select, active low (asynchronous) |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the data-out pad |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Writes `tx_data` into the holding register |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe that marks a new `rx_data` |
| rx_take | input | 1 | Marks the received byte as consumed |
| rx_overrun | output | 1 | A byte arrived before the previous one was taken |
| fault_flag | output | 1 | Sticky flag for an aborted byte |

## Verification
If the bit counter is in the wrong state, `rx_valid` fires one or more serial clock cycles early or late. A byte can also be lost, or an extra one delivered. The bench catches this at the end of the affected byte because it counts strobes and compares `rx_data`. If the shift register is wrong or the phase mapping is reversed, the master sees a wrong MISO bit at the very next sampling point, and every bit is checked at that point. Errors in abort handling show up on the byte that follows the abort: it either arrives misaligned or does not arrive. A fault flag that is set wrongly is visible a few cycles after select rises.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam int SYNC_DEPTH = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edges_t;

    typedef struct packed {
        logic lead;
        logic trail;
    } phase_ev_t;

    // Map raw serial clock edges onto leading/trailing for a given polarity
    function automatic phase_ev_t map_edges(logic cpol, edges_t e);
        phase_ev_t r;
        r.lead  = cpol ? e.fall : e.rise;
        r.trail = cpol ? e.rise : e.fall;
        return r;
    endfunction
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) st[0] <= RST_VAL;
        else     st[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) st[g] <= RST_VAL;
            else     st[g] <= st[g-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/spi_slv_edges.sv
module spi_slv_edges
    import spi_slv_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   lvl,
    output edges_t ev
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= lvl;
    end

    assign ev.rise = lvl & ~prev_q;
    assign ev.fall = ~lvl & prev_q;
endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core
    import spi_slv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cpol,
    input  logic   cpha,
    input  edges_t sck_ev,
    input  edges_t sel_ev,
    input  logic   sel_s,
    input  logic   mosi_s,
    input  logic   fault_en,
    input  logic   fault_clr,
    input  byte_t  tx_data,
    input  logic   tx_load,
    input  logic   rx_take,
    output logic   miso_bit,
    output byte_t  rx_data,
    output logic   rx_valid,
    output logic   rx_overrun,
    output logic   fault_flag
);
    localparam cnt_t LAST = cnt_t'(BYTE_W - 1);
    localparam cnt_t DONE = cnt_t'(BYTE_W);

    phase_ev_t ev;
    byte_t     hold_q, tx_sh, rx_sh, rx_next;
    cnt_t      cnt;
    logic      rx_full, mid_byte;

    always_comb begin
        ev       = map_edges(cpol, sck_ev);
        rx_next  = {rx_sh[BYTE_W-2:0], mosi_s};
        mid_byte = (cnt != '0) && (cnt != DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            rx_data    <= '0;
            cnt        <= '0;
            rx_valid   <= 1'b0;
            rx_full    <= 1'b0;
            rx_overrun <= 1'b0;
            fault_flag <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (tx_load) hold_q <= tx_data;
            if (rx_take) begin
                rx_full    <= 1'b0;
                rx_overrun <= 1'b0;
            end
            if (fault_clr) fault_flag <= 1'b0;
            if (sel_ev.rise && mid_byte && fault_en) fault_flag <= 1'b1;

            if (sel_s || sel_ev.fall) begin
                // idle or byte start: preload, drop any partial byte
                cnt   <= '0;
                tx_sh <= hold_q;
                rx_sh <= '0;
            end else if (!cpha) begin
                if (ev.lead && cnt != DONE) begin
                    rx_sh <= rx_next;
                    cnt   <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        rx_data  <= rx_next;
                        rx_valid <= 1'b1;
                        if (rx_full && !rx_take) rx_overrun <= 1'b1;
                        rx_full  <= 1'b1;
                    end
                end
                if (ev.trail && mid_byte) tx_sh <= tx_sh << 1;
            end else begin
                if (ev.lead) begin
                    if (cnt == '0) tx_sh <= hold_q;
                    else           tx_sh <= tx_sh << 1;
                end
                if (ev.trail) begin
                    rx_sh <= rx_next;
                    if (cnt == LAST) begin
                        cnt      <= '0;
                        rx_data  <= rx_next;
                        rx_valid <= 1'b1;
                        if (rx_full && !rx_take) rx_overrun <= 1'b1;
                        rx_full  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    assign miso_bit = tx_sh[BYTE_W-1];

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= DONE);
    assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
    assert_done_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!cpha && cnt == DONE && !sel_s && !sel_ev.fall) |=> (cnt == DONE));
    assert_idle_clear_R6: assert property (@(posedge clk) disable iff (rst)
        sel_s |=> (cnt == '0 && !rx_valid));
    assert_fault_gated_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_flag) |-> ($past(fault_en) && $past(sel_ev.rise)));
    assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> (rx_valid && $past(rx_full)));
endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine
    import spi_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              fault_en,
    input  logic              fault_clr,
    input  logic              pin_sck,
    input  logic              pin_mosi,
    input  logic              pin_sel_n,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_load,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_take,
    output logic              rx_overrun,
    output logic              fault_flag
);
    logic [2:0] pins_s;
    edges_t     sck_ev, sel_ev;

    spi_slv_sync #(.W(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pin_sel_n, pin_mosi, pin_sck}),
        .q   (pins_s)
    );

    spi_slv_edges #(.RST_VAL(1'b0)) u_sck_edges (
        .clk (clk), .rst (rst), .lvl (pins_s[0]), .ev (sck_ev)
    );

    spi_slv_edges #(.RST_VAL(1'b1)) u_sel_edges (
        .clk (clk), .rst (rst), .lvl (pins_s[2]), .ev (sel_ev)
    );

    spi_slv_core u_core (
        .clk        (clk),
        .rst        (rst),
        .cpol       (cfg_cpol),
        .cpha       (cfg_cpha),
        .sck_ev     (sck_ev),
        .sel_ev     (sel_ev),
        .sel_s      (pins_s[2]),
        .mosi_s     (pins_s[1]),
        .fault_en   (fault_en),
        .fault_clr  (fault_clr),
        .tx_data    (tx_data),
        .tx_load    (tx_load),
        .rx_take    (rx_take),
        .miso_bit   (miso_out),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_overrun (rx_overrun),
        .fault_flag (fault_flag)
    );

    // Pad enable follows the raw select so release is immediate
    assign miso_oe = ~pin_sel_n;
endmodule

// File: tb/spi_slave_engine_tb.sv
`timescale 1ns/1ps
module spi_slave_engine_tb_top;
    localparam int H = 8; // half serial clock period in system clocks

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpol = 1'b0, cpha = 1'b0, fault_en = 1'b0, fault_clr = 1'b0;
    logic sck = 1'b0, mosi = 1'b0, seln = 1'b1;
    logic [7:0] tx_data = '0;
    logic tx_load = 1'b0, rx_take = 1'b0;
    logic miso_out, miso_oe, rx_valid, rx_overrun, fault_flag;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    int rx_cnt = 0;
    logic [7:0] rx_last = '0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_slave_engine dut_i (
        .clk(clk), .rst(rst), .cfg_cpol(cpol), .cfg_cpha(cpha),
        .fault_en(fault_en), .fault_clr(fault_clr),
        .pin_sck(sck), .pin_mosi(mosi), .pin_sel_n(seln),
        .miso_out(miso_out), .miso_oe(miso_oe),
        .tx_data(tx_data), .tx_load(tx_load),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_take(rx_take),
        .rx_overrun(rx_overrun), .fault_flag(fault_flag)
    );

    always @(posedge clk) begin
        if (!rst && rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_load(input logic [7:0] v);
        tx_data = v; tx_load = 1'b1; wclk(1); tx_load = 1'b0; wclk(1);
    endtask

    task automatic take();
        rx_take = 1'b1; wclk(1); rx_take = 1'b0; wclk(1);
    endtask

    task automatic set_mode(input logic p, input logic h);
        cpol = p; cpha = h; sck = p; wclk(6);
    endtask

    // Master side: shift n bits; check MISO before each master sampling edge
    task automatic bits(input logic [7:0] mo, input logic [7:0] mi, input int n,
                        input bit chk_mi, input string req);
        for (int i = 0; i < n; i++) begin
            if (!cpha) begin
                mosi = mo[7-i];
                wclk(H);
                if (chk_mi) chk(miso_out == mi[7-i] && miso_oe, req, "miso bit", miso_out, mi[7-i]);
                sck = ~cpol; wclk(H); sck = cpol;
            end else begin
                sck = ~cpol; mosi = mo[7-i];
                wclk(H);
                if (chk_mi) chk(miso_out == mi[7-i] && miso_oe, req, "miso bit", miso_out, mi[7-i]);
                sck = cpol; wclk(H);
            end
        end
        wclk(H);
    endtask

    task automatic t_reset();
        chk(miso_oe == 1'b0, "R5", "oe at reset", miso_oe, 0);
        chk(rx_valid == 1'b0 && rx_overrun == 1'b0, "R9", "flags at reset", {rx_valid, rx_overrun}, 0);
        chk(fault_flag == 1'b0, "R7", "fault at reset", fault_flag, 0);
    endtask

    task automatic t_mode0();
        int c0;
        set_mode(1'b0, 1'b0);
        pulse_load(8'hA5);
        c0 = rx_cnt;
        seln = 1'b0; wclk(6);
        chk(miso_oe && miso_out == 1'b1, "R2", "msb before first edge", miso_out, 1);
        bits(8'h3C, 8'hA5, 8, 1'b1, "R2");
        chk(rx_cnt == c0 + 1, "R1", "one strobe per byte", rx_cnt - c0, 1);
        chk(rx_last == 8'h3C, "R1", "rx byte mode0", rx_last, 8'h3C);
        // R3: more clocks without a select toggle are ignored
        bits(8'hFF, 8'h00, 8, 1'b0, "R3");
        chk(rx_cnt == c0 + 1, "R3", "extra clocks ignored", rx_cnt - c0, 1);
        seln = 1'b1; wclk(4);
        chk(miso_oe == 1'b0, "R5", "oe off after select high", miso_oe, 0);
        take();
    endtask

    task automatic t_mode3_stream();
        int c0;
        set_mode(1'b1, 1'b1);
        pulse_load(8'h5A);
        c0 = rx_cnt;
        seln = 1'b0; wclk(6);
        bits(8'h81, 8'h5A, 8, 1'b1, "R4");
        chk(rx_cnt == c0 + 1 && rx_last == 8'h81, "R4", "first stream byte", rx_last, 8'h81);
        take();
        bits(8'h7E, 8'h5A, 8, 1'b1, "R8");
        chk(rx_cnt == c0 + 2 && rx_last == 8'h7E, "R4", "second byte select held low", rx_last, 8'h7E);
        take();
        pulse_load(8'hC3);
        bits(8'h42, 8'hC3, 8, 1'b1, "R8");
        chk(rx_last == 8'h42, "R4", "third stream byte", rx_last, 8'h42);
        seln = 1'b1; wclk(6); take();
    endtask

    task automatic t_other_modes();
        set_mode(1'b1, 1'b0);
        pulse_load(8'h96);
        seln = 1'b0; wclk(6);
        chk(miso_out == 1'b1, "R2", "msb mode2", miso_out, 1);
        bits(8'hE1, 8'h96, 8, 1'b1, "R2");
        chk(rx_last == 8'hE1, "R2", "rx byte mode2", rx_last, 8'hE1);
        seln = 1'b1; wclk(6); take();
        set_mode(1'b0, 1'b1);
        pulse_load(8'h2D);
        seln = 1'b0; wclk(6);
        bits(8'h1B, 8'h2D, 8, 1'b1, "R4");
        chk(rx_last == 8'h1B, "R4", "rx byte mode1", rx_last, 8'h1B);
        seln = 1'b1; wclk(6); take();
    endtask

    task automatic t_idle_ignored();
        int c0;
        set_mode(1'b0, 1'b1);
        c0 = rx_cnt;
        for (int i = 0; i < 10; i++) begin
            sck = ~sck; mosi = ~mosi; wclk(H);
        end
        sck = cpol; wclk(6);
        chk(rx_cnt == c0, "R6", "clocks with select high", rx_cnt - c0, 0);
        chk(miso_oe == 1'b0, "R5", "oe while idle clocks", miso_oe, 0);
    endtask

    task automatic t_abort();
        int c0;
        set_mode(1'b0, 1'b0);
        pulse_load(8'hF0);
        fault_en = 1'b1;
        c0 = rx_cnt;
        seln = 1'b0; wclk(6);
        bits(8'hAA, 8'hF0, 3, 1'b0, "R6");
        seln = 1'b1; wclk(6);
        chk(rx_cnt == c0, "R6", "partial byte dropped", rx_cnt - c0, 0);
        chk(fault_flag == 1'b1, "R7", "fault on abort", fault_flag, 1);
        fault_clr = 1'b1; wclk(1); fault_clr = 1'b0; wclk(1);
        chk(fault_flag == 1'b0, "R7", "fault cleared", fault_flag, 0);
        fault_en = 1'b0;
        seln = 1'b0; wclk(6);
        bits(8'h55, 8'hF0, 5, 1'b0, "R7");
        seln = 1'b1; wclk(6);
        chk(fault_flag == 1'b0, "R7", "no fault when disabled", fault_flag, 1'b0);
        seln = 1'b0; wclk(6);
        bits(8'h69, 8'hF0, 8, 1'b1, "R6");
        chk(rx_cnt == c0 + 1 && rx_last == 8'h69, "R6", "byte after abort aligned", rx_last, 8'h69);
        seln = 1'b1; wclk(6); take();
    endtask

    task automatic t_overrun();
        set_mode(1'b0, 1'b1);
        pulse_load(8'h33);
        seln = 1'b0; wclk(6);
        bits(8'h11, 8'h33, 8, 1'b0, "R9");
        chk(rx_overrun == 1'b0, "R9", "no overrun first byte", rx_overrun, 0);
        bits(8'h22, 8'h33, 8, 1'b0, "R9");
        chk(rx_overrun == 1'b1 && rx_last == 8'h22, "R9", "overrun on untaken byte", rx_overrun, 1);
        seln = 1'b1; wclk(6);
        take();
        chk(rx_overrun == 1'b0, "R9", "take clears overrun", rx_overrun, 0);
    endtask

    initial begin
        wclk(4);
        rst = 1'b0;
        wclk(4);
        t_reset();
        t_mode0();
        t_mode3_stream();
        t_other_modes();
        t_idle_ignored();
        t_abort();
        t_overrun();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule